// File: doc/BRIEF.md
# Idle-to-sleep power timer

This block decides the power state of a flash-disk controller. It keeps one of three states (active, idle, sleep). It watches the host for inactivity and puts the device to sleep when the host has been quiet for a programmed time. It also carries out the power-management commands that the command decoder passes to it. The decoder gives it a one-cycle command strobe, a 3-bit class code and the sector-count byte. A separate strobe marks every host access to the data register. A one-cycle tick arrives once per millisecond.

Time is counted in 5 ms steps: five ticks make one step. An Idle command programs the number of steps from its sector count. A sector count of zero selects three steps, which is also the setting after reset. Every accepted command and every data-register access starts the countdown again from the programmed value. When the countdown runs out, the block enters sleep without any help from the host. In sleep the countdown is frozen. Any later command wakes the device, so no reset is needed.

For the power commands the block returns a fixed sequence of single-cycle pulses, which the surrounding logic uses to set busy, clear busy and request an interrupt. The check-power command adds one more pulse that writes zero into the sector-count register.

Top module: `pwr_idle_timer`

## Requirements
- R1: While reset is asserted and right after it, `pwr_state_o` is 0 (active), `sleep_en_o` is 0, all four pulse outputs are 0, and the programmed step count is 3.
- R2: `pwr_state_o` encodes 0 = active, 1 = idle, 2 = sleep and never takes the value 3. `sleep_en_o` is 1 exactly when the state is 2.
- R3: An Idle command (class 1) with a nonzero sector count N sets the state to idle in the next cycle. Sleep is then entered after N*5 ticks with no further host activity.
- R4: An Idle command with a sector count of 0 programs 3 steps, so sleep follows after 15 ticks.
- R5: After reset, with no host activity, the state becomes sleep in the cycle after the 15th tick.
- R6: When the countdown expires, the state becomes sleep in the cycle after the final tick, and no pulse output is raised.
- R7: Standby (class 3), Standby Immediate (class 4) and Sleep (class 5) set the state to sleep in the next cycle. Starting one cycle after the strobe, the block pulses `set_busy_o`, then `clr_busy_o`, then `irq_req_o`, each high for one cycle on successive cycles.
- R8: Check Power (class 6) pulses `set_busy_o`, `sc_zero_wr_o`, `clr_busy_o` and `irq_req_o` on four successive cycles starting one cycle after the strobe. It keeps an active or idle state unchanged.
- R9: A command received while in sleep wakes the device. Classes 1 and 2 lead to idle. Classes 0, 6 and 7 lead to active.
- R10: Every accepted command and every `host_access_i` pulse restart the countdown from the programmed step count and restart the 5-tick divider. A reload in the same cycle as a tick takes priority over that tick. An access alone never changes the state.
- R11: Idle Immediate (class 2) sets the state to idle and issues the same three pulses as R7. It leaves the programmed step count unchanged.
- R12: Classes 0 and 7 raise no pulse output. They leave an active or idle state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| cmd_valid_i | input | 1 | One-cycle strobe: a command was accepted |
| cmd_class_i | input | 3 | Decoded class: 0 other, 1 idle, 2 idle immediate, 3 standby, 4 standby immediate, 5 sleep, 6 check power |
| sector_cnt_i | input | 8 | Sector-count byte that comes with the command |
| host_access_i | input | 1 | One-cycle pulse for a host data-register access |
| pwr_state_o | output | 2 | Current power state (0 active, 1 idle, 2 sleep) |
| sleep_en_o | output | 1 | Sleep enable for unused circuitry |
| set_busy_o | output | 1 | Pulse: set busy |
| clr_busy_o | output | 1 | Pulse: clear busy |
| irq_req_o | output | 1 | Pulse: raise interrupt |
| sc_zero_wr_o | output | 1 | Pulse: write 00h into the sector-count register |

## Verification
The assertions assume that `cmd_valid_i`, `host_access_i` and `tick_ms_i` are single-cycle pulses. They also assume that the host does not issue a new command while a pulse sequence is still running. The ordering checks on the pulses depend on that.

The stimulus keeps to these assumptions. Each tick is followed by a quiet cycle, and commands are spaced at least five cycles apart. The one place where events deliberately overlap is a single command that lands in the same cycle as a tick, which exercises the reload priority.

// File: rtl/pwr_timer_pkg.sv
package pwr_timer_pkg;

    typedef enum logic [2:0] {
        CMD_OTHER    = 3'd0,
        CMD_IDLE     = 3'd1,
        CMD_IDLE_NOW = 3'd2,
        CMD_STBY     = 3'd3,
        CMD_STBY_NOW = 3'd4,
        CMD_SLEEP    = 3'd5,
        CMD_CHKPWR   = 3'd6
    } cmd_class_e;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_IDLE   = 2'd1,
        PS_SLEEP  = 2'd2
    } pwr_state_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_SET  = 3'd1,
        RSP_WR   = 3'd2,
        RSP_CLR  = 3'd3,
        RSP_IRQ  = 3'd4
    } rsp_phase_e;

endpackage

// File: rtl/pwr_step_prescaler.sv
module pwr_step_prescaler #(
    parameter int TICKS_PER_STEP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic step_o
);
    localparam int PRE_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_STEP - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = 1'b0;
        if (clear_i) begin
            st_d.pre = '0;
        end else if (run_i && tick_i) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                step_o   = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwr_inact_counter.sv
module pwr_inact_counter #(
    parameter int STEP_W        = 8,
    parameter int DEFAULT_STEPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    input  logic              load_en_i,
    input  logic [STEP_W-1:0] load_val_i,
    input  logic              step_i,
    output logic              expire_o
);
    localparam logic [STEP_W-1:0] DEF_STEPS = STEP_W'(DEFAULT_STEPS);
    localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

    typedef struct packed {
        logic [STEP_W-1:0] prog;
        logic [STEP_W-1:0] left;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_en_i) begin
            st_d.prog = load_val_i;
            st_d.left = load_val_i;
        end else if (reload_i) begin
            st_d.left = st_q.prog;
        end else if (step_i && (st_q.left != '0)) begin
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == ONE_STEP) expire_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prog <= DEF_STEPS;
            st_q.left <= DEF_STEPS;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwr_resp_seq.sv
module pwr_resp_seq
    import pwr_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic with_wr_i,
    output logic set_busy_o,
    output logic sc_zero_wr_o,
    output logic clr_busy_o,
    output logic irq_req_o
);
    typedef struct packed {
        rsp_phase_e phase;
        logic       wr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = RSP_SET;
            st_d.wr    = with_wr_i;
        end else begin
            unique case (st_q.phase)
                RSP_SET: st_d.phase = st_q.wr ? RSP_WR : RSP_CLR;
                RSP_WR:  st_d.phase = RSP_CLR;
                RSP_CLR: st_d.phase = RSP_IRQ;
                default: st_d.phase = RSP_NONE;
            endcase
        end
    end

    assign set_busy_o   = (st_q.phase == RSP_SET);
    assign sc_zero_wr_o = (st_q.phase == RSP_WR);
    assign clr_busy_o   = (st_q.phase == RSP_CLR);
    assign irq_req_o    = (st_q.phase == RSP_IRQ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= RSP_NONE;
            st_q.wr    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer
    import pwr_timer_pkg::*;
#(
    parameter int TICKS_PER_STEP = 5,
    parameter int SC_W           = 8,
    parameter int DEFAULT_STEPS  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_ms_i,
    input  logic            cmd_valid_i,
    input  logic [2:0]      cmd_class_i,
    input  logic [SC_W-1:0] sector_cnt_i,
    input  logic            host_access_i,
    output logic [1:0]      pwr_state_o,
    output logic            sleep_en_o,
    output logic            set_busy_o,
    output logic            clr_busy_o,
    output logic            irq_req_o,
    output logic            sc_zero_wr_o
);
    localparam logic [SC_W-1:0] DEF_STEPS = SC_W'(DEFAULT_STEPS);

    typedef struct packed {
        pwr_state_e st;
    } top_state_t;

    top_state_t st_d, st_q;

    logic            is_idle_cls, is_sleep_cls, is_chk_cls, is_resp_cls;
    logic            reload, load_en, step, expire, run;
    logic [SC_W-1:0] load_val;

    always_comb begin
        is_idle_cls  = (cmd_class_i == CMD_IDLE) || (cmd_class_i == CMD_IDLE_NOW);
        is_sleep_cls = (cmd_class_i == CMD_STBY) || (cmd_class_i == CMD_STBY_NOW)
                    || (cmd_class_i == CMD_SLEEP);
        is_chk_cls   = (cmd_class_i == CMD_CHKPWR);
        is_resp_cls  = is_idle_cls || is_sleep_cls || is_chk_cls;
    end

    assign reload   = cmd_valid_i || host_access_i;
    assign load_en  = cmd_valid_i && (cmd_class_i == CMD_IDLE);
    assign load_val = (sector_cnt_i == '0) ? DEF_STEPS : sector_cnt_i;
    assign run      = (st_q.st != PS_SLEEP);

    pwr_step_prescaler #(
        .TICKS_PER_STEP (TICKS_PER_STEP)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (reload),
        .run_i   (run),
        .tick_i  (tick_ms_i),
        .step_o  (step)
    );

    pwr_inact_counter #(
        .STEP_W        (SC_W),
        .DEFAULT_STEPS (DEFAULT_STEPS)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .load_en_i  (load_en),
        .load_val_i (load_val),
        .step_i     (step),
        .expire_o   (expire)
    );

    pwr_resp_seq u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (cmd_valid_i && is_resp_cls),
        .with_wr_i    (is_chk_cls),
        .set_busy_o   (set_busy_o),
        .sc_zero_wr_o (sc_zero_wr_o),
        .clr_busy_o   (clr_busy_o),
        .irq_req_o    (irq_req_o)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_valid_i) begin
            if (is_idle_cls)                st_d.st = PS_IDLE;
            else if (is_sleep_cls)          st_d.st = PS_SLEEP;
            else if (st_q.st == PS_SLEEP)   st_d.st = PS_ACTIVE;
        end else if (expire) begin
            st_d.st = PS_SLEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.st <= PS_ACTIVE;
        else        st_q    <= st_d;
    end

    assign pwr_state_o = st_q.st;
    assign sleep_en_o  = (st_q.st == PS_SLEEP);
endmodule

// File: rtl/pwr_idle_timer_chk.sv
module pwr_idle_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_ms_i,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_class_i,
    input logic       host_access_i,
    input logic [1:0] pwr_state_o,
    input logic       sleep_en_o,
    input logic       set_busy_o,
    input logic       clr_busy_o,
    input logic       irq_req_o,
    input logic       sc_zero_wr_o
);
    logic sleep_grp;
    logic idle_grp;
    logic plain_grp;
    assign sleep_grp = (cmd_class_i == 3'd3) || (cmd_class_i == 3'd4) || (cmd_class_i == 3'd5);
    assign idle_grp  = (cmd_class_i == 3'd1) || (cmd_class_i == 3'd2);
    assign plain_grp = (cmd_class_i == 3'd0) || (cmd_class_i == 3'd7);

    a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o != 2'd3);

    a_r7_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_busy_o, sc_zero_wr_o, clr_busy_o, irq_req_o}));

    a_r7_set_then_next: assert property (@(posedge clk) disable iff (!rst_n)
        (set_busy_o && !cmd_valid_i) |=> (clr_busy_o || sc_zero_wr_o));

    a_r8_wr_then_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_zero_wr_o && !cmd_valid_i) |=> clr_busy_o);

    a_r7_clr_then_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy_o && !cmd_valid_i) |=> irq_req_o);

    a_r7_sleep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && sleep_grp) |=> (pwr_state_o == 2'd2 && sleep_en_o && set_busy_o));

    a_r3_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && idle_grp) |=> (pwr_state_o == 2'd1 && !sleep_en_o));

    a_r9_wake_active: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (plain_grp || cmd_class_i == 3'd6) && pwr_state_o == 2'd2)
        |=> (pwr_state_o == 2'd0));

    a_r12_plain_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && plain_grp) |=> !set_busy_o);

    a_r6_auto_sleep_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o == 2'd2 && $past(pwr_state_o) != 2'd2 && !$past(cmd_valid_i))
        |-> $past(tick_ms_i));

    a_r10_access_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (host_access_i && !cmd_valid_i) |=> (pwr_state_o == $past(pwr_state_o)));
endmodule

bind pwr_idle_timer pwr_idle_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_ms_i     (tick_ms_i),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_class_i   (cmd_class_i),
    .host_access_i (host_access_i),
    .pwr_state_o   (pwr_state_o),
    .sleep_en_o    (sleep_en_o),
    .set_busy_o    (set_busy_o),
    .clr_busy_o    (clr_busy_o),
    .irq_req_o     (irq_req_o),
    .sc_zero_wr_o  (sc_zero_wr_o)
);

// File: tb/tb_pwr_idle_timer.sv
module tb_pwr_idle_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_class = 3'd0;
    logic [7:0] sector_cnt = 8'd0;
    logic       host_access = 1'b0;
    logic [1:0] pwr_state;
    logic       sleep_en, set_busy, clr_busy, irq_req, sc_zero_wr;

    always #5 clk = ~clk;

    pwr_idle_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .cmd_valid_i(cmd_valid),
        .cmd_class_i(cmd_class), .sector_cnt_i(sector_cnt), .host_access_i(host_access),
        .pwr_state_o(pwr_state), .sleep_en_o(sleep_en), .set_busy_o(set_busy),
        .clr_busy_o(clr_busy), .irq_req_o(irq_req), .sc_zero_wr_o(sc_zero_wr)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference model, in ticks rather than steps
    int m_state, m_prog, m_rem, m_pulse;
    int m_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_prog = 3; m_rem = 15; m_pulse = 0; m_q.delete();
        end else begin
            m_pulse = (m_q.size() > 0) ? m_q.pop_front() : 0;
            if (cmd_valid) begin
                case (cmd_class)
                    3'd1: begin m_prog = (sector_cnt == 0) ? 3 : int'(sector_cnt); m_state = 1; end
                    3'd2: m_state = 1;
                    3'd3, 3'd4, 3'd5: m_state = 2;
                    default: if (m_state == 2) m_state = 0;
                endcase
                if (cmd_class >= 3'd1 && cmd_class <= 3'd6) begin
                    m_q.delete();
                    m_pulse = 1;
                    if (cmd_class == 3'd6) m_q.push_back(2);
                    m_q.push_back(3);
                    m_q.push_back(4);
                end
                m_rem = m_prog * 5;
            end else if (host_access) begin
                m_rem = m_prog * 5;
            end else if (tick && m_state != 2 && m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) m_state = 2;
            end
        end
    end

    task automatic check_eq(int act, int exp, string req, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pulse_code();
        int n;
        n = int'(set_busy) + int'(sc_zero_wr) + int'(clr_busy) + int'(irq_req);
        if (n > 1) return 9;
        if (set_busy) return 1;
        if (sc_zero_wr) return 2;
        if (clr_busy) return 3;
        if (irq_req) return 4;
        return 0;
    endfunction

    // per-cycle comparison against the model (R2 state/sleep enable, pulses)
    always @(negedge clk) begin
        if (!done) begin
            check_eq(int'(pwr_state), m_state, cur_req, "state");
            check_eq(int'(sleep_en), (m_state == 2) ? 1 : 0, "R2", "sleep_en");
            check_eq(pulse_code(), m_pulse, cur_req, "pulse");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic cmd(int cls, int sc);
        cmd_valid = 1'b1; cmd_class = 3'(cls); sector_cnt = 8'(sc);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic access();
        host_access = 1'b1; @(negedge clk);
        host_access = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_seq(int cls, bit with_wr, string req);
        cmd_valid = 1'b1; cmd_class = 3'(cls); sector_cnt = 8'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_eq(int'(set_busy), 1, req, "set_busy");
        @(negedge clk);
        if (with_wr) begin
            check_eq(int'(sc_zero_wr), 1, req, "sc_zero_wr");
            @(negedge clk);
        end
        check_eq(int'(clr_busy), 1, req, "clr_busy");
        @(negedge clk);
        check_eq(int'(irq_req), 1, req, "irq_req");
        @(negedge clk);
        check_eq(pulse_code(), 0, req, "pulses idle");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_eq(int'(pwr_state), 0, "R1", "reset state");
        check_eq(pulse_code(), 0, "R1", "reset pulses");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq(int'(pwr_state), 0, "R1", "state after reset");

        cur_req = "R5";
        ticks(14);
        check_eq(int'(pwr_state), 0, "R5", "before 15th tick");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R5", "after 15th tick");
        check_eq(int'(sleep_en), 1, "R2", "sleep enable");

        cur_req = "R12";
        cmd(0, 0);
        check_eq(int'(pwr_state), 0, "R9", "other wakes to active");
        cmd(7, 0);
        check_eq(int'(pwr_state), 0, "R12", "class 7 keeps active");

        cur_req = "R3";
        cmd(1, 2);
        check_eq(int'(pwr_state), 1, "R3", "idle entered");
        ticks(9);
        check_eq(int'(pwr_state), 1, "R3", "before 10 ticks");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R3", "after 10 ticks");

        cur_req = "R10";
        cmd(1, 2);
        ticks(7);
        access();
        check_eq(int'(pwr_state), 1, "R10", "access keeps idle");
        ticks(9);
        check_eq(int'(pwr_state), 1, "R10", "reloaded by access");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R10", "expiry after reload");

        cur_req = "R4";
        cmd(1, 0);
        ticks(14);
        check_eq(int'(pwr_state), 1, "R4", "zero count before 15");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R4", "zero count after 15");

        cur_req = "R11";
        cmd(1, 4);
        ticks(6);
        pulse_seq(2, 1'b0, "R11");
        check_eq(int'(pwr_state), 1, "R11", "idle immediate");
        ticks(19);
        check_eq(int'(pwr_state), 1, "R11", "program kept before 20");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R11", "program kept after 20");

        cur_req = "R8";
        cmd(1, 3);
        pulse_seq(6, 1'b1, "R8");
        check_eq(int'(pwr_state), 1, "R8", "check keeps idle");
        cur_req = "R7";
        pulse_seq(5, 1'b0, "R7");
        check_eq(int'(pwr_state), 2, "R7", "sleep command");
        cur_req = "R8";
        cmd(6, 0);
        check_eq(int'(pwr_state), 0, "R9", "check wakes to active");

        cur_req = "R7";
        pulse_seq(3, 1'b0, "R7");
        check_eq(int'(pwr_state), 2, "R7", "standby");
        cmd(0, 0);
        pulse_seq(4, 1'b0, "R7");
        check_eq(int'(pwr_state), 2, "R7", "standby immediate");
        cur_req = "R9";
        cmd(1, 1);
        check_eq(int'(pwr_state), 1, "R9", "idle wakes to idle");

        cur_req = "R6";
        ticks(4);
        tick = 1'b1; cmd_valid = 1'b1; cmd_class = 3'd0;
        @(negedge clk);
        tick = 1'b0; cmd_valid = 1'b0;
        @(negedge clk);
        check_eq(int'(pwr_state), 1, "R10", "cmd beats final tick");
        ticks(4);
        check_eq(int'(pwr_state), 1, "R6", "before expiry");
        ticks(1);
        check_eq(int'(pwr_state), 2, "R6", "auto sleep");
        check_eq(pulse_code(), 0, "R6", "no pulse on expiry");
        ticks(6);
        check_eq(int'(pwr_state), 2, "R6", "stays asleep");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule